// File: doc/BRIEF.md
# Eight-Input Prioritised Interrupt Controller

This block collects up to eight interrupt requests from peripherals and presents a single interrupt line to the processor. Each request input is latched into a pending register. An input is latched either on its rising edge or while its level is high, and the choice is programmed. Requests can be blocked one by one through a mask register. A fixed priority picks the winner: input 0 ranks highest and input 7 lowest. The interrupt line rises only when an unmasked pending request ranks above every level already being serviced.

The processor programs the block through a small register port with one address bit. It first writes three setup words: trigger style and vector spacing, then the vector base, then the automatic-completion option. After that, writes go either to the mask or to a command register. The command register selects which status register is read and issues end-of-interrupt commands. On a one-cycle acknowledge pulse, the winning request moves from pending to in-service. One cycle later the block presents a vector equal to the base plus the input index times four or eight, with an 8-bit wrap. In automatic mode, nothing is recorded as in service.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset, and until the three-word setup is complete, `int_out` stays low whatever the request inputs do. `vec_vld` is low, and reads at both addresses return 0x00.
- R2: A write to address 0 with bit 4 set starts setup. In that word, bit 3 = 1 selects level triggering and bit 2 = 1 selects spacing 4 (0 selects spacing 8). The next write to address 1 is the vector base. The write after that is the options word, where bit 0 = 1 enables automatic completion. Starting setup clears the mask, pending and in-service registers.
- R3: In edge mode, a request is latched on a 0-to-1 transition of its input. Once acknowledged, it is not requested again until the input has gone low and risen again.
- R4: In level mode, the pending bit follows the input. A request whose input falls before acknowledge disappears from the pending register and from `int_out`.
- R5: After setup, a write to address 1 loads the mask (bit i = 1 blocks input i), and a read of address 1 returns it. A masked request never raises `int_out` and is never granted.
- R6: `int_out` is high only when the lowest-index unmasked pending bit has a lower index than every set in-service bit.
- R7: An acknowledge while `int_out` is high clears the winning pending bit and sets its in-service bit. In the next cycle, `vec_vld` is high for one cycle with `vec_o` = base + index × spacing, modulo 256.
- R8: Both spacings (4 and 8) and base wraparound past 0xFF produce the vector given by R7.
- R9: A command write to address 0 with bit 4 = 0 and bit 3 = 1 selects what a read of address 0 returns: bit 0 = 0 gives the pending register, bit 0 = 1 gives the in-service register.
- R10: A command with bits 4 and 3 clear, bit 5 set and bit 6 clear clears the lowest-index set in-service bit.
- R11: A command with bits 4 and 3 clear and bits 5 and 6 set clears the in-service bit named by bits 2:0.
- R12: With automatic completion enabled, an acknowledge clears the pending bit and emits the vector, but no in-service bit is ever set.
- R13: An acknowledge while `int_out` is low emits the vector of index 7 and leaves the pending and in-service registers unchanged.
- R14: When an acknowledge and an end-of-interrupt command fall in the same cycle, the command acts on the in-service register as it was before that cycle, and the newly granted bit is still set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register port select |
| rd | input | 1 | Read strobe, qualified by `sel` |
| wr | input | 1 | Write strobe, qualified by `sel` |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; 0x00 when no read is in progress |
| irq_in | input | 8 | Interrupt request inputs |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | One-cycle acknowledge pulse from the processor |
| vec_o | output | 8 | Vector of the granted request |
| vec_vld | output | 1 | `vec_o` is valid this cycle |

## Verification
The acknowledge and an end-of-interrupt command both update the in-service register, so they can fall in the same clock edge. The bench provokes this with the in-service register holding input 3 and input 1 pending, then raises `ack` and writes a non-specific end-of-interrupt command in one cycle. The result passes only if the vector is that of input 1 and a later in-service read shows 0x02. That value means the command removed the older level and the grant was kept. A second overlap, a fresh rising edge meeting the clear of a pending bit, is covered by the edge-mode rule that the input must fall before it is taken again.

// File: rtl/irq_ctrl8_pkg.sv
package irq_ctrl8_pkg;

    localparam int NUM_IRQ = 8;
    localparam int IDX_W   = $clog2(NUM_IRQ);
    localparam int DATA_W  = 8;

    // command-word bit positions decoded by the register port
    localparam int SETUP_BIT   = 4;
    localparam int LEVEL_BIT   = 3;
    localparam int SPC4_BIT    = 2;
    localparam int RDSEL_BIT   = 3;
    localparam int EOI_BIT     = 5;
    localparam int SPECIFIC_BIT = 6;
    localparam int AEOI_BIT    = 0;

    typedef enum logic [1:0] {
        SETUP_IDLE,
        SETUP_BASE,
        SETUP_OPTS,
        SETUP_RUN
    } setup_state_e;

    typedef struct packed {
        logic              level_trig;
        logic              spc_four;
        logic              auto_eoi;
        logic [DATA_W-1:0] base;
    } ctl_cfg_t;

    typedef struct packed {
        logic             valid;
        logic             specific;
        logic [IDX_W-1:0] idx;
    } eoi_cmd_t;

    // lowest set index wins; returns 0 for an empty vector
    function automatic logic [IDX_W-1:0] first_set(input logic [NUM_IRQ-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    function automatic logic [NUM_IRQ-1:0] idx_onehot(input logic [IDX_W-1:0] idx);
        return NUM_IRQ'(1) << idx;
    endfunction

    function automatic logic [DATA_W-1:0] vec_calc(input logic [DATA_W-1:0] base,
                                                   input logic [IDX_W-1:0]  idx,
                                                   input logic              spc4);
        logic [DATA_W-1:0] off;
        off = spc4 ? DATA_W'({idx, 2'b00}) : DATA_W'({idx, 3'b000});
        return base + off;
    endfunction

endpackage

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
    import irq_ctrl8_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sel,
    input  logic               rd,
    input  logic               wr,
    input  logic               addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_IRQ-1:0] irr,
    input  logic [NUM_IRQ-1:0] isr,
    output logic [DATA_W-1:0]  rdata,
    output ctl_cfg_t           cfg,
    output logic [NUM_IRQ-1:0] mask,
    output logic               running,
    output logic               setup_start,
    output eoi_cmd_t           eoi
);

    setup_state_e state;
    logic         show_isr;
    logic         wr_en;
    logic         cmd_wr;

    assign wr_en       = sel && wr;
    assign setup_start = wr_en && !addr && wdata[SETUP_BIT];
    assign cmd_wr      = wr_en && !addr && !wdata[SETUP_BIT] && (state == SETUP_RUN);
    assign running     = (state == SETUP_RUN);

    always_comb begin
        eoi.valid    = cmd_wr && !wdata[RDSEL_BIT] && wdata[EOI_BIT];
        eoi.specific = wdata[SPECIFIC_BIT];
        eoi.idx      = wdata[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SETUP_IDLE;
            cfg      <= '0;
            mask     <= '0;
            show_isr <= 1'b0;
        end else if (setup_start) begin
            state          <= SETUP_BASE;
            cfg.level_trig <= wdata[LEVEL_BIT];
            cfg.spc_four   <= wdata[SPC4_BIT];
            cfg.auto_eoi   <= 1'b0;
            mask           <= '0;
            show_isr       <= 1'b0;
        end else if (wr_en && addr) begin
            case (state)
                SETUP_BASE: begin
                    cfg.base <= wdata;
                    state    <= SETUP_OPTS;
                end
                SETUP_OPTS: begin
                    cfg.auto_eoi <= wdata[AEOI_BIT];
                    state        <= SETUP_RUN;
                end
                SETUP_RUN:  mask <= wdata[NUM_IRQ-1:0];
                default:    ;
            endcase
        end else if (cmd_wr && wdata[RDSEL_BIT]) begin
            show_isr <= wdata[0];
        end
    end

    always_comb begin
        if (sel && rd) begin
            if (addr)          rdata = mask;
            else if (show_isr) rdata = isr;
            else               rdata = irr;
        end else begin
            rdata = '0;
        end
    end

    // R2
    setup_clears_mask_chk: assert property (@(posedge clk) disable iff (rst)
        setup_start |=> (mask == '0) && !running);

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irq_ctrl8_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               level_trig,
    input  logic               running,
    input  logic               clear,
    input  logic [NUM_IRQ-1:0] take,
    output logic [NUM_IRQ-1:0] irr
);

    logic [NUM_IRQ-1:0] irq_q;
    logic [NUM_IRQ-1:0] rise;

    assign rise = irq_in & ~irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            irr   <= '0;
        end else begin
            irq_q <= irq_in;
            if (clear || !running)
                irr <= '0;
            else if (level_trig)
                irr <= irq_in & ~take;
            else
                irr <= (irr & ~take) | rise;
        end
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit_chk
        // R3
        req_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(irr[g]) |-> $past(irq_in[g]));
    end

endmodule

// File: rtl/irq_prio.sv
module irq_prio
    import irq_ctrl8_pkg::*;
(
    input  logic [NUM_IRQ-1:0] irr,
    input  logic [NUM_IRQ-1:0] mask,
    input  logic [NUM_IRQ-1:0] isr,
    input  logic               running,
    output logic               int_req,
    output logic [IDX_W-1:0]   win_idx
);

    logic [NUM_IRQ-1:0] pending;
    logic [IDX_W-1:0]   isr_top;

    assign pending = irr & ~mask;
    assign win_idx = first_set(pending);
    assign isr_top = first_set(isr);
    assign int_req = running && (|pending) && ((isr == '0) || (win_idx < isr_top));

    always_comb begin
        // R5
        masked_no_win_chk: assert (!int_req || !mask[win_idx]);
        // R6
        in_service_blocks_chk: assert (!int_req || !isr[win_idx]);
    end

endmodule

// File: rtl/irq_service.sv
module irq_service
    import irq_ctrl8_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               ack,
    input  logic               int_req,
    input  logic [IDX_W-1:0]   win_idx,
    input  logic [DATA_W-1:0]  base,
    input  logic               spc_four,
    input  logic               auto_eoi,
    input  eoi_cmd_t           eoi,
    output logic [NUM_IRQ-1:0] isr,
    output logic [NUM_IRQ-1:0] take,
    output logic [DATA_W-1:0]  vec_o,
    output logic               vec_vld
);

    logic               grant;
    logic [IDX_W-1:0]   vec_idx;
    logic [NUM_IRQ-1:0] done_mask;
    logic [NUM_IRQ-1:0] set_mask;

    assign grant    = ack && int_req;
    assign take     = grant ? idx_onehot(win_idx) : '0;
    assign vec_idx  = grant ? win_idx : IDX_W'(NUM_IRQ - 1);
    assign set_mask = (grant && !auto_eoi) ? idx_onehot(win_idx) : '0;

    always_comb begin
        done_mask = '0;
        if (eoi.valid) begin
            if (eoi.specific)  done_mask = idx_onehot(eoi.idx);
            else if (|isr)     done_mask = idx_onehot(first_set(isr));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr     <= '0;
            vec_o   <= '0;
            vec_vld <= 1'b0;
        end else begin
            vec_vld <= ack;
            if (ack) vec_o <= vec_calc(base, vec_idx, spc_four);
            if (clear) isr <= '0;
            else       isr <= (isr & ~done_mask) | set_mask;
        end
    end

    // R7
    grant_sets_isr_chk: assert property (@(posedge clk) disable iff (rst)
        grant && !auto_eoi && !clear |=> isr[$past(win_idx)]);
    // R7
    vld_follows_ack_chk: assert property (@(posedge clk) disable iff (rst)
        vec_vld |-> $past(ack));
    // R12
    aeoi_isr_empty_chk: assert property (@(posedge clk) disable iff (rst)
        auto_eoi |-> (isr == '0));
    // R13
    spurious_keeps_isr_chk: assert property (@(posedge clk) disable iff (rst)
        ack && !int_req && !eoi.valid && !clear |=> $stable(isr));

endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
    import irq_ctrl8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              rd,
    input  logic              wr,
    input  logic              addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [7:0]        irq_in,
    output logic              int_out,
    input  logic              ack,
    output logic [7:0]        vec_o,
    output logic              vec_vld
);

    ctl_cfg_t           cfg;
    eoi_cmd_t           eoi;
    logic [NUM_IRQ-1:0] mask;
    logic [NUM_IRQ-1:0] irr;
    logic [NUM_IRQ-1:0] isr;
    logic [NUM_IRQ-1:0] take;
    logic [IDX_W-1:0]   win_idx;
    logic               running;
    logic               setup_start;

    irq_bus_regs u_regs (
        .clk(clk), .rst(rst), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .irr(irr), .isr(isr), .rdata(rdata), .cfg(cfg),
        .mask(mask), .running(running), .setup_start(setup_start), .eoi(eoi)
    );

    irq_req_latch u_req (
        .clk(clk), .rst(rst), .irq_in(irq_in), .level_trig(cfg.level_trig),
        .running(running), .clear(setup_start), .take(take), .irr(irr)
    );

    irq_prio u_prio (
        .irr(irr), .mask(mask), .isr(isr), .running(running),
        .int_req(int_out), .win_idx(win_idx)
    );

    irq_service u_svc (
        .clk(clk), .rst(rst), .clear(setup_start), .ack(ack), .int_req(int_out),
        .win_idx(win_idx), .base(cfg.base), .spc_four(cfg.spc_four),
        .auto_eoi(cfg.auto_eoi), .eoi(eoi), .isr(isr), .take(take),
        .vec_o(vec_o), .vec_vld(vec_vld)
    );

    // R5
    int_needs_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        int_out |-> |(irr & ~mask));

endmodule

// File: tb/test_irq_ctrl8.sv
`timescale 1ns/1ps
module test_irq_ctrl8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0, rd = 1'b0, wr = 1'b0, addr = 1'b0, ack = 1'b0;
    logic [7:0] wdata = '0, irq_in = '0;
    logic [7:0] rdata, vec_o;
    logic       int_out, vec_vld;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    irq_ctrl8 i_irq_ctrl8 (
        .clk(clk), .rst(rst), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .int_out(int_out),
        .ack(ack), .vec_o(vec_o), .vec_vld(vec_vld)
    );

    typedef struct packed {
        logic       spc4;
        logic [7:0] base;
        logic [7:0] irqs;
        logic [7:0] mask;
        logic       exp_int;
        logic [7:0] exp_vec;
    } row_t;

    localparam row_t ROWS [6] = '{
        '{1'b0, 8'h20, 8'h08, 8'h00, 1'b1, 8'h38},
        '{1'b1, 8'h40, 8'h28, 8'h00, 1'b1, 8'h4C},
        '{1'b0, 8'h00, 8'h81, 8'h01, 1'b1, 8'h38},
        '{1'b1, 8'hF0, 8'h40, 8'h00, 1'b1, 8'h08},
        '{1'b0, 8'h10, 8'h0F, 8'h0F, 1'b0, 8'h48},
        '{1'b0, 8'hC8, 8'hFF, 8'h00, 1'b1, 8'hC8}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; addr = a;
        #1 d = rdata;
        sel = 1'b0; rd = 1'b0;
    endtask

    task automatic setup(input logic lvl, input logic spc4, input logic [7:0] base, input logic aeoi);
        bus_wr(1'b0, {3'b000, 1'b1, lvl, spc4, 2'b00});
        bus_wr(1'b1, base);
        bus_wr(1'b1, {7'd0, aeoi});
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog R1: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        #1;
        check("R1 int_out", {7'd0, int_out}, 8'h00);
        check("R1 vec_vld", {7'd0, vec_vld}, 8'h00);
        bus_rd(1'b0, d); check("R1 read addr0", d, 8'h00);
        bus_rd(1'b1, d); check("R1 read addr1", d, 8'h00);
        set_irq(8'h01);
        check("R1 int before setup", {7'd0, int_out}, 8'h00);
        set_irq(8'h00);

        // table walk: R5 R6 R7 R8 R13
        foreach (ROWS[k]) begin
            setup(1'b0, ROWS[k].spc4, ROWS[k].base, 1'b0);
            bus_wr(1'b1, ROWS[k].mask);
            set_irq(ROWS[k].irqs);
            check("R5/R6 table int_out", {7'd0, int_out}, {7'd0, ROWS[k].exp_int});
            pulse_ack();
            check("R7 table vec_vld", {7'd0, vec_vld}, 8'h01);
            check("R8 table vector", vec_o, ROWS[k].exp_vec);
            set_irq(8'h00);
        end

        // R2 setup clears mask
        setup(1'b0, 1'b0, 8'h80, 1'b0);
        bus_rd(1'b1, d); check("R2 mask after setup", d, 8'h00);
        bus_wr(1'b1, 8'h5A);
        bus_rd(1'b1, d); check("R5 mask readback", d, 8'h5A);
        setup(1'b0, 1'b0, 8'h80, 1'b0);
        bus_rd(1'b1, d); check("R2 mask cleared by new setup", d, 8'h00);

        // R3 edge behaviour
        set_irq(8'h04);
        check("R3 edge raises int", {7'd0, int_out}, 8'h01);
        pulse_ack();
        check("R7 vector idx2", vec_o, 8'h90);
        @(negedge clk);
        check("R7 vec_vld one cycle", {7'd0, vec_vld}, 8'h00);
        check("R6 int low after grant", {7'd0, int_out}, 8'h00);
        bus_rd(1'b0, d); check("R3 pending cleared, input held", d, 8'h00);
        bus_wr(1'b0, 8'h20);
        @(negedge clk);
        check("R3 held input not retaken", {7'd0, int_out}, 8'h00);
        set_irq(8'h00);
        set_irq(8'h04);
        check("R3 new edge retaken", {7'd0, int_out}, 8'h01);
        pulse_ack();
        bus_wr(1'b0, 8'h20);
        set_irq(8'h00);

        // R6 nesting, R9 R10 R11
        set_irq(8'h20);
        pulse_ack();
        check("R7 vector idx5", vec_o, 8'hA8);
        set_irq(8'h60);
        check("R6 lower level blocked", {7'd0, int_out}, 8'h00);
        set_irq(8'h62);
        check("R6 higher level passes", {7'd0, int_out}, 8'h01);
        pulse_ack();
        check("R6 vector idx1", vec_o, 8'h88);
        bus_wr(1'b0, 8'h09);
        bus_rd(1'b0, d); check("R9 in-service read", d, 8'h22);
        bus_wr(1'b0, 8'h20);
        bus_rd(1'b0, d); check("R10 non-specific clears top", d, 8'h20);
        bus_wr(1'b0, 8'h65);
        bus_rd(1'b0, d); check("R11 specific clears idx5", d, 8'h00);
        check("R11 pending idx6 now raises", {7'd0, int_out}, 8'h01);
        bus_wr(1'b0, 8'h08);
        bus_rd(1'b0, d); check("R9 pending read", d, 8'h40);
        set_irq(8'h00);

        // R4 level mode
        setup(1'b1, 1'b1, 8'h00, 1'b0);
        set_irq(8'h10);
        check("R4 level raises int", {7'd0, int_out}, 8'h01);
        bus_rd(1'b0, d); check("R4 pending follows input", d, 8'h10);
        set_irq(8'h00);
        check("R4 dropped before ack", {7'd0, int_out}, 8'h00);
        bus_rd(1'b0, d); check("R4 pending gone", d, 8'h00);

        // R12 automatic completion
        setup(1'b0, 1'b1, 8'h40, 1'b1);
        set_irq(8'h08);
        pulse_ack();
        check("R12 vector idx3", vec_o, 8'h4C);
        bus_wr(1'b0, 8'h09);
        bus_rd(1'b0, d); check("R12 in-service empty", d, 8'h00);
        check("R12 int low after grant", {7'd0, int_out}, 8'h00);
        set_irq(8'h0C);
        check("R12 lower level not blocked", {7'd0, int_out}, 8'h01);
        pulse_ack();
        check("R12 vector idx2", vec_o, 8'h48);

        // R13 spurious acknowledge
        pulse_ack();
        check("R13 spurious vector", vec_o, 8'h5C);
        bus_rd(1'b0, d); check("R13 in-service unchanged", d, 8'h00);
        bus_wr(1'b0, 8'h08);
        bus_rd(1'b0, d); check("R13 pending unchanged", d, 8'h00);
        set_irq(8'h00);

        // R14 acknowledge and completion in one cycle
        setup(1'b0, 1'b0, 8'h00, 1'b0);
        set_irq(8'h08);
        pulse_ack();
        check("R7 vector idx3", vec_o, 8'h18);
        set_irq(8'h0A);
        check("R14 int before overlap", {7'd0, int_out}, 8'h01);
        @(negedge clk);
        ack = 1'b1; sel = 1'b1; wr = 1'b1; addr = 1'b0; wdata = 8'h20;
        @(negedge clk);
        ack = 1'b0; sel = 1'b0; wr = 1'b0;
        check("R14 vector idx1", vec_o, 8'h08);
        bus_wr(1'b0, 8'h09);
        bus_rd(1'b0, d); check("R14 in-service after overlap", d, 8'h02);
        set_irq(8'h00);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule